// File: doc/BRIEF.md
# Hardwired Instruction Step Sequencer

This block is the control unit of a compact 8-bit CPU whose instructions and data sit in separate memories. It watches the 4-bit opcode held in the instruction register and walks a one-hot step register through up to five states. In every state it emits a control word that tells the datapath what to do: which unit drives the bus, which register loads, whether the ALU subtracts, and whether memory reads or writes. The control word is built in a fixed AND/OR matrix from a decoded opcode line and the current step line. No microcode store is involved.

The first two states are the same for every instruction: fetch the instruction from the address held in the program counter, then latch it and advance the counter. After that, each opcode runs its own short sequence. On its final step the block raises a one-cycle end pulse and reloads the step register to its first state. The two conditional branches leave early when their flag is clear. A stop instruction sets a sticky halted state, which freezes the sequencer until reset. The datapath, the memories and the ALU are outside this block.

Top module: `seq_ctrl_unit`

## Requirements
- R1: With `rst` high at a clock edge, the next cycle is the first step: `ctrl` shows only bits 0 and 1, `halted` is 0 and `instr_done` is 0.
- R2: For every opcode, the first cycle of an instruction drives `ctrl` = bits 0 and 1 only (instruction address, instruction read), and the second cycle drives bits 2 and 3 only (instruction latch, PC increment).
- R3: Opcodes 0x0 idle, 0x1 stop, 0x4 register copy, 0x7 output, 0xD read PC and 0xE jump to register each take 3 cycles, counted from the first step up to and including the cycle with `instr_done` high.
- R4: Opcodes 0x5 load immediate, 0x6 store through register address, 0x8 jump and 0xC load through register address each take 4 cycles.
- R5: Opcodes 0x2 add, 0x3 subtract, 0xB load from immediate address and 0xF store to immediate address each take 5 cycles. No instruction runs longer than 5.
- R6: Opcode 0x9 branches on `flag_z` and 0xA on `flag_c`. Each takes 3 cycles when its own flag is 0 and 5 cycles when it is 1. The other flag has no effect.
- R7: `instr_done` is high for exactly one cycle per instruction. The cycle after it is the first step of the next instruction.
- R8: ALU subtract (bit 10) is asserted during subtract and never during add.
- R9: A taken branch asserts PC load (bit 4) on its last cycle. A branch not taken never asserts PC load and asserts PC increment (bit 3) in its third cycle.
- R10: After a stop instruction ends, `halted` is 1, `ctrl` is all zero and `instr_done` stays 0 until reset, which clears `halted`.
- R11: PC load and PC increment are never high together. Data read (bit 14) and data write (bit 15) are never high together.
- R12: Control bit map: 0 instruction address from PC, 1 instruction read, 2 instruction latch, 3 PC increment, 4 PC load, 5 PC to bus, 6 register read, 7 register write, 8 ALU operand latch, 9 ALU result latch, 10 ALU subtract, 11 ALU result to bus, 12 flag load, 13 data address latch, 14 data read, 15 data write, 16 output latch, 17 halt request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 4 | Opcode from the instruction register |
| flag_z | input | 1 | Zero flag from the datapath |
| flag_c | input | 1 | Carry flag from the datapath |
| ctrl | output | 18 | Control word, bit map per R12 |
| instr_done | output | 1 | One-cycle pulse on the final step of an instruction |
| halted | output | 1 | Sticky halted state |

## Verification
The assertions check on every cycle that the step register is one-hot and returns to its first state after an end pulse. They also check that no step runs past the fifth, that halt is entered only on a halt request and then stays set with a silent control word, and that the PC and data-memory strobes never collide. Only the bench's scenarios can show that each opcode has the right length, that each branch outcome has its own length and PC strobe pattern, that subtract is told apart from add, and that reset restores the fetch word.

// File: rtl/seqctl_pkg.sv
package seqctl_pkg;

  typedef enum logic [3:0] {
    OP_IDLE = 4'h0,
    OP_STOP = 4'h1,
    OP_ADD  = 4'h2,
    OP_SUB  = 4'h3,
    OP_COPY = 4'h4,
    OP_LDI  = 4'h5,
    OP_STR  = 4'h6,
    OP_EMIT = 4'h7,
    OP_JUMP = 4'h8,
    OP_BRZ  = 4'h9,
    OP_BRC  = 4'hA,
    OP_LDA  = 4'hB,
    OP_LDR  = 4'hC,
    OP_RDPC = 4'hD,
    OP_JREG = 4'hE,
    OP_STA  = 4'hF
  } opcode_e;

  // control word bit positions
  localparam int CB_PC_ADDR = 0;
  localparam int CB_IMEM_RD = 1;
  localparam int CB_IR_LD   = 2;
  localparam int CB_PC_INC  = 3;
  localparam int CB_PC_LD   = 4;
  localparam int CB_PC_OE   = 5;
  localparam int CB_RF_RD   = 6;
  localparam int CB_RF_WR   = 7;
  localparam int CB_TMP_LD  = 8;
  localparam int CB_ACC_LD  = 9;
  localparam int CB_ALU_SUB = 10;
  localparam int CB_ALU_OE  = 11;
  localparam int CB_FLAG_LD = 12;
  localparam int CB_MAR_LD  = 13;
  localparam int CB_DMEM_RD = 14;
  localparam int CB_DMEM_WR = 15;
  localparam int CB_OUT_LD  = 16;
  localparam int CB_HALT    = 17;
  localparam int CW_BITS    = 18;

  localparam int STEPS_MIN  = 5;

endpackage

// File: rtl/seqctl_op_dec.sv
module seqctl_op_dec #(
  parameter int OP_W = 4,
  localparam int OP_N = 1 << OP_W
) (
  input  logic [OP_W-1:0] opcode,
  output logic [OP_N-1:0] op_hot
);

  for (genvar i = 0; i < OP_N; i++) begin : g_line
    assign op_hot[i] = (opcode == OP_W'(i));
  end

endmodule

// File: rtl/seqctl_step_ctr.sv
module seqctl_step_ctr #(
  parameter int STEP_N = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              last,
  output logic [STEP_N-1:0] step_q
);

  localparam logic [STEP_N-1:0] FIRST = STEP_N'(1);

  always_ff @(posedge clk) begin
    if (rst)
      step_q <= FIRST;
    else if (hold)
      step_q <= step_q;
    else if (last)
      step_q <= FIRST;
    else
      step_q <= {step_q[STEP_N-2:0], 1'b0};
  end

  assert_step_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $countones(step_q) == 1);

  assert_reload_first_R7: assert property (@(posedge clk) disable iff (rst)
    (last && !hold) |=> step_q[0]);

  assert_no_overrun_R5: assert property (@(posedge clk) disable iff (rst)
    (step_q[STEP_N-1] && !hold) |-> last);

endmodule

// File: rtl/seqctl_matrix.sv
module seqctl_matrix
  import seqctl_pkg::*;
#(
  parameter int OP_N   = 16,
  parameter int STEP_N = 5,
  parameter int CW_W   = CW_BITS
) (
  input  logic [OP_N-1:0]   op_hot,
  input  logic [STEP_N-1:0] step,
  input  logic              zf,
  input  logic              cf,
  output logic [CW_W-1:0]   ctrl,
  output logic              last
);

  logic t0, t1, t2, t3, t4;
  logic idle, stop, add, sub, copy, ldi, str, emit;
  logic jump, brz, brc, lda, ldr, rdpc, jreg, sta;
  logic br_tk, br_nt, fetch_opnd, arith;

  assign t0 = step[0];
  assign t1 = step[1];
  assign t2 = step[2];
  assign t3 = step[3];
  assign t4 = step[4];

  assign idle = op_hot[OP_IDLE];
  assign stop = op_hot[OP_STOP];
  assign add  = op_hot[OP_ADD];
  assign sub  = op_hot[OP_SUB];
  assign copy = op_hot[OP_COPY];
  assign ldi  = op_hot[OP_LDI];
  assign str  = op_hot[OP_STR];
  assign emit = op_hot[OP_EMIT];
  assign jump = op_hot[OP_JUMP];
  assign brz  = op_hot[OP_BRZ];
  assign brc  = op_hot[OP_BRC];
  assign lda  = op_hot[OP_LDA];
  assign ldr  = op_hot[OP_LDR];
  assign rdpc = op_hot[OP_RDPC];
  assign jreg = op_hot[OP_JREG];
  assign sta  = op_hot[OP_STA];

  assign br_tk      = (brz & zf) | (brc & cf);
  assign br_nt      = (brz & ~zf) | (brc & ~cf);
  assign arith      = add | sub;
  assign fetch_opnd = t2 & (ldi | jump | lda | sta | br_tk);

  always_comb begin
    ctrl = '0;
    ctrl[CB_PC_ADDR] = t0 | fetch_opnd;
    ctrl[CB_IMEM_RD] = t0 | fetch_opnd;
    ctrl[CB_IR_LD]   = t1;
    ctrl[CB_PC_INC]  = t1 | (t2 & br_nt) | (t3 & (ldi | lda | sta));
    ctrl[CB_PC_LD]   = (t2 & jreg) | (t3 & jump) | (t4 & br_tk);
    ctrl[CB_PC_OE]   = t2 & rdpc;
    ctrl[CB_RF_RD]   = (t2 & (arith | copy | str | emit | ldr | jreg))
                     | (t3 & (arith | str)) | (t4 & sta);
    ctrl[CB_RF_WR]   = (t2 & (copy | rdpc)) | (t3 & (ldi | ldr))
                     | (t4 & (arith | lda));
    ctrl[CB_TMP_LD]  = t2 & arith;
    ctrl[CB_ACC_LD]  = t3 & arith;
    ctrl[CB_ALU_SUB] = t3 & sub;
    ctrl[CB_FLAG_LD] = t3 & arith;
    ctrl[CB_ALU_OE]  = t4 & arith;
    ctrl[CB_MAR_LD]  = (t2 & (str | ldr)) | (t3 & (lda | sta | br_tk));
    ctrl[CB_DMEM_RD] = (t3 & ldr) | (t4 & lda);
    ctrl[CB_DMEM_WR] = (t3 & str) | (t4 & sta);
    ctrl[CB_OUT_LD]  = t2 & emit;
    ctrl[CB_HALT]    = t2 & stop;
  end

  assign last = (t2 & (idle | stop | copy | emit | rdpc | jreg | br_nt))
              | (t3 & (ldi | str | jump | ldr))
              | (t4 & (arith | lda | sta | br_tk));

endmodule

// File: rtl/seq_ctrl_unit.sv
module seq_ctrl_unit
  import seqctl_pkg::*;
#(
  parameter int OP_W   = 4,
  parameter int STEP_N = STEPS_MIN,
  parameter int CW_W   = CW_BITS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  input  logic            flag_z,
  input  logic            flag_c,
  output logic [CW_W-1:0] ctrl,
  output logic            instr_done,
  output logic            halted
);

  localparam int OP_N = 1 << OP_W;

  logic [OP_N-1:0]   op_hot;
  logic [STEP_N-1:0] step_q;
  logic [CW_W-1:0]   mat_ctrl;
  logic              mat_last;
  logic              halt_q;

  seqctl_op_dec #(.OP_W(OP_W)) u_dec (
    .opcode (opcode),
    .op_hot (op_hot)
  );

  seqctl_step_ctr #(.STEP_N(STEP_N)) u_step (
    .clk    (clk),
    .rst    (rst),
    .hold   (halt_q),
    .last   (instr_done),
    .step_q (step_q)
  );

  seqctl_matrix #(.OP_N(OP_N), .STEP_N(STEP_N), .CW_W(CW_W)) u_mat (
    .op_hot (op_hot),
    .step   (step_q),
    .zf     (flag_z),
    .cf     (flag_c),
    .ctrl   (mat_ctrl),
    .last   (mat_last)
  );

  always_ff @(posedge clk) begin
    if (rst)
      halt_q <= 1'b0;
    else if (mat_ctrl[CB_HALT])
      halt_q <= 1'b1;
  end

  assign ctrl       = halt_q ? '0 : mat_ctrl;
  assign instr_done = mat_last & ~halt_q;
  assign halted     = halt_q;

  assert_halt_entry_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(halt_q) |-> $past(mat_ctrl[CB_HALT]));

  assert_halt_hold_R10: assert property (@(posedge clk) disable iff (rst)
    halt_q |=> halt_q);

  assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    halted |-> (ctrl == '0 && !instr_done));

  assert_pc_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(ctrl[CB_PC_LD] && ctrl[CB_PC_INC]));

  assert_dmem_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(ctrl[CB_DMEM_RD] && ctrl[CB_DMEM_WR]));

endmodule

// File: tb/seq_ctrl_unit_tb.sv
`timescale 1ns/1ps
module seq_ctrl_unit_tb;

  // R12 bit map
  localparam int B_PC_INC  = 3;
  localparam int B_PC_LD   = 4;
  localparam int B_ALU_SUB = 10;
  localparam int B_DMEM_RD = 14;
  localparam int B_DMEM_WR = 15;
  localparam logic [17:0] W_T0 = 18'h00003;
  localparam logic [17:0] W_T1 = 18'h0000C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  opcode = 4'h0;
  logic        flag_z = 1'b0;
  logic        flag_c = 1'b0;
  logic [17:0] ctrl;
  logic        instr_done;
  logic        halted;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int    exp_len_q[$];
  string exp_tag_q[$];

  always #2.5 clk = ~clk;

  seq_ctrl_unit u_dut (
    .clk        (clk),
    .rst        (rst),
    .opcode     (opcode),
    .flag_z     (flag_z),
    .flag_c     (flag_c),
    .ctrl       (ctrl),
    .instr_done (instr_done),
    .halted     (halted)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [3:0] op, input logic z, input logic c);
    case (op)
      4'h0, 4'h1, 4'h4, 4'h7, 4'hD, 4'hE: return 3;
      4'h5, 4'h6, 4'h8, 4'hC:             return 4;
      4'h9:                               return z ? 5 : 3;
      4'hA:                               return c ? 5 : 3;
      default:                            return 5;
    endcase
  endfunction

  function automatic string len_tag(input logic [3:0] op);
    case (op)
      4'h0, 4'h1, 4'h4, 4'h7, 4'hD, 4'hE: return "R3 length";
      4'h5, 4'h6, 4'h8, 4'hC:             return "R4 length";
      4'h9, 4'hA:                         return "R6 length";
      default:                            return "R5 length";
    endcase
  endfunction

  // monitor: scoreboard on instruction length
  always @(negedge clk) begin
    #1;
    if (rst) cyc = 0;
    else if (!halted) begin
      cyc++;
      if (instr_done) begin
        if (exp_len_q.size() == 0)
          chk(1'b0, "R7 unexpected end pulse", cyc, 0);
        else begin
          int    e;
          string t;
          e = exp_len_q.pop_front();
          t = exp_tag_q.pop_front();
          chk(cyc == e, t, cyc, e);
        end
        cyc = 0;
      end
    end
  end

  // driver: called at a negedge where the first step is visible
  task automatic run_op(input logic [3:0] op, input logic z, input logic c);
    int n = 0;
    int dones = 0;
    bit saw_sub = 0, saw_pcld = 0, pcld_last = 0, pcinc_t2 = 0, excl_bad = 0;
    bit d;
    exp_len_q.push_back(exp_len(op, z, c));
    exp_tag_q.push_back(len_tag(op));
    opcode = op; flag_z = z; flag_c = c;
    do begin
      #1;
      n++;
      if (n == 1) chk(ctrl == W_T0, "R2/R12 fetch word", ctrl, W_T0);
      if (n == 2) chk(ctrl == W_T1, "R2/R12 latch word", ctrl, W_T1);
      if (ctrl[B_ALU_SUB]) saw_sub = 1;
      if (ctrl[B_PC_LD]) begin saw_pcld = 1; pcld_last = instr_done; end
      if (n == 3 && ctrl[B_PC_INC]) pcinc_t2 = 1;
      if ((ctrl[B_PC_LD] && ctrl[B_PC_INC]) || (ctrl[B_DMEM_RD] && ctrl[B_DMEM_WR]))
        excl_bad = 1;
      d = instr_done;
      if (d) dones++;
      @(negedge clk);
    end while (!d && n < 8);
    chk(dones == 1, "R7 single end pulse", dones, 1);
    chk(!excl_bad, "R11 strobe exclusion", excl_bad, 0);
    if (op == 4'h2) chk(!saw_sub, "R8 add without subtract", saw_sub, 0);
    if (op == 4'h3) chk(saw_sub, "R8 subtract strobe", saw_sub, 1);
    if ((op == 4'h9 && z) || (op == 4'hA && c))
      chk(saw_pcld && pcld_last, "R9 taken branch loads PC last", {saw_pcld, pcld_last}, 2'b11);
    if ((op == 4'h9 && !z) || (op == 4'hA && !c))
      chk(!saw_pcld && pcinc_t2, "R9 untaken branch skips", {saw_pcld, pcinc_t2}, 2'b01);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(ctrl == W_T0 && !halted && !instr_done, "R1 reset state", {halted, instr_done, ctrl}, W_T0);

    for (int i = 0; i < 16; i++)
      if (i != 1) run_op(4'(i), 1'b0, 1'b0);
    run_op(4'h9, 1'b1, 1'b0);   // R6 zero branch taken
    run_op(4'hA, 1'b0, 1'b1);   // R6 carry branch taken
    run_op(4'h9, 1'b0, 1'b1);   // R6 other flag ignored
    run_op(4'hA, 1'b1, 1'b0);   // R6 other flag ignored
    run_op(4'h3, 1'b1, 1'b1);
    run_op(4'h2, 1'b1, 1'b1);
    run_op(4'hF, 1'b1, 1'b0);

    run_op(4'h1, 1'b0, 1'b0);   // stop, R10
    #1;
    chk(halted, "R10 halted after stop", halted, 1);
    begin
      bit quiet = 1;
      for (int k = 0; k < 10; k++) begin
        opcode = 4'(k + 2);
        #0.5;
        if (ctrl != '0 || instr_done) quiet = 0;
        @(negedge clk);
        #1;
      end
      chk(quiet, "R10 quiet while halted", quiet, 1);
    end

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(ctrl == W_T0 && !halted && !instr_done, "R1 R10 reset clears halt", {halted, instr_done, ctrl}, W_T0);
    run_op(4'hB, 1'b0, 1'b0);
    run_op(4'h8, 1'b0, 1'b0);

    repeat (2) @(negedge clk);
    chk(exp_len_q.size() == 0, "R7 all instructions ended", exp_len_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule